// File: doc/BRIEF.md
# Input Period Capture Channel

This timer channel measures the period of a digital input that has already been filtered and brought into the clock domain. The channel is armed by a mode enable. Once armed, it reacts to edges of one polarity only, rising or falling, chosen by a select input. At each such edge it records the value of an external free-running time-base bus. The stamps pass down a short chain of registers. A capture register (A2) and a holding register (B2) receive the new stamp. The earlier B2 value moves on into a period-start register (B1) and into a spare register (A1).

Software reads the end stamp through data port A and the start stamp through data port B. The period is port A minus port B. Reading port A freezes the path from B2 into B1, and reading port B releases it again. Because of this, a read of A followed by a read of B always returns a matched pair, even when edges keep arriving between the two reads. The channel also holds a completion flag. The flag is set once a full period has been captured, and software clears it by writing one to it.

Top module: `period_capture_chan`

## Requirements
- R1: With `edge_rise`=1 only 0-to-1 transitions of `sig_in` are qualifying edges; with `edge_rise`=0 only 1-to-0 transitions are. A transition of the other polarity changes no register and does not set the flag.
- R2: A qualifying transition made before a clock edge is captured at the next rising clock: A2 and B2 take the `tbase` value sampled at that clock, and B1 takes the previous B2 when transfers are not blocked.
- R3: On the second and every later qualifying edge since mode entry, A1 takes the previous B2 value; on the first edge A1 stays 0.
- R4: The first qualifying edge after mode entry does not set the flag.
- R5: Every later qualifying edge sets the flag.
- R6: `bus_rdata` combinationally returns A2 for `bus_addr`=0, B1 for `bus_addr`=1, and the flag in bit 0 (other bits 0) for `bus_addr`=2, whenever `bus_rd`=1; it is 0 otherwise.
- R7: A read at address 0 copies A1 into B1 and blocks later B2-to-B1 transfers, so edges that follow leave B1 unchanged.
- R8: A read at address 1 copies A1 into B1 and re-enables B2-to-B1 transfers from the next qualifying edge on.
- R9: The flag stays set until a write at address 2 with `bus_wdata` bit 0 = 1; when that write and a flag-setting edge occur in the same cycle, the flag ends up set.
- R10: Reset, or `mode_en`=0 for one clock, clears A1, A2, B1, B2, the flag, the first-edge tracker and the block state.
- R11: When a port read and a qualifying edge occur in the same clock, the edge update is done first and B1 then takes the A1 value that results from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Filtered synchronous input being measured |
| tbase | input | TB_W | Free-running time-base bus |
| edge_rise | input | 1 | 1: rising edges qualify, 0: falling edges qualify |
| mode_en | input | 1 | Channel enable for period measurement |
| bus_addr | input | 2 | 0 port A, 1 port B, 2 flag |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | TB_W | Write data, bit 0 clears the flag |
| bus_rdata | output | TB_W | Read data |
| flag | output | 1 | Completion flag |

## Verification
The hardest situation to reach is an edge that lands between the port A read and the port B read. This is where the block has to keep B1 frozen while A1 keeps advancing. The bench reaches it by reading port A, sending two more edges, and then reading port B. It checks that the pair is still the old one and that the next pair follows at once. A second hard case is a port read issued in the same clock as an edge. The bench drives both strobes on the same falling clock edge, so the capture and the read land on the same rising edge.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    SEL_END   = 2'd0,
    SEL_START = 2'd1,
    SEL_FLAG  = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;
endpackage

// File: rtl/pcc_edge_det.sv
module pcc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic sig_in,
  input  logic edge_rise,
  output logic qual
);
  logic sig_q;

  function automatic logic edge_hit(input logic now, input logic prev, input logic rise);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign qual = mode_en & edge_hit(sig_in, sig_q, edge_rise);

  p_wrong_pol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_in == sig_q) |-> !qual);
  p_pol_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> (sig_in == edge_rise));
endmodule

// File: rtl/pcc_shadow_regs.sv
module pcc_shadow_regs #(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_en,
  input  logic            qual,
  input  logic [TB_W-1:0] tbase,
  input  logic            rd_end,
  input  logic            rd_start,
  output logic [TB_W-1:0] a2,
  output logic [TB_W-1:0] b1,
  output logic            first_edge,
  output logic            later_edge
);
  logic [TB_W-1:0] a1, b2;
  logic [TB_W-1:0] a1_nx, a2_nx, b1_nx, b2_nx;
  logic            seen, blocked, blocked_nx, any_rd;

  assign first_edge = qual & ~seen;
  assign later_edge = qual & seen;
  assign any_rd     = rd_end | rd_start;

  always_comb begin
    a1_nx = a1;
    a2_nx = a2;
    b1_nx = b1;
    b2_nx = b2;
    blocked_nx = blocked;
    if (qual) begin
      a2_nx = tbase;
      b2_nx = tbase;
      if (!blocked) b1_nx = b2;
      if (seen)     a1_nx = b2;
    end
    if (any_rd) b1_nx = a1_nx;
    if (rd_end)        blocked_nx = 1'b1;
    else if (rd_start) blocked_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
      seen <= 1'b0; blocked <= 1'b0;
    end else if (!mode_en) begin
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
      seen <= 1'b0; blocked <= 1'b0;
    end else begin
      a1 <= a1_nx; a2 <= a2_nx; b1 <= b1_nx; b2 <= b2_nx;
      blocked <= blocked_nx;
      if (qual) seen <= 1'b1;
    end
  end

  p_a2_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && mode_en) |=> (a2 == $past(tbase)));
  p_b1_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && mode_en && !blocked && !any_rd) |=> (b1 == $past(b2)));
  p_a1_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_edge && mode_en) |=> $stable(a1));
  p_b1_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && mode_en && !any_rd) |=> $stable(b1));
  p_unblock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && mode_en) |=> !blocked);
  p_rd_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd && mode_en) |=> (b1 == a1));
endmodule

// File: rtl/pcc_flag.sv
module pcc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (!mode_en) flag <= 1'b0;
    else if (set_evt)  flag <= 1'b1;
    else if (clr_evt)  flag <= 1'b0;
  end

  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && mode_en) |=> flag);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && mode_en && !clr_evt) |=> flag);
  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !flag);
endmodule

// File: rtl/period_capture_chan.sv
module period_capture_chan #(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sig_in,
  input  logic [TB_W-1:0] tbase,
  input  logic            edge_rise,
  input  logic            mode_en,
  input  logic [1:0]      bus_addr,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [TB_W-1:0] bus_wdata,
  output logic [TB_W-1:0] bus_rdata,
  output logic            flag
);
  import pcc_pkg::*;

  logic            qual, first_edge, later_edge;
  logic            rd_end, rd_start, clr_evt;
  logic [TB_W-1:0] a2, b1;
  sel_e            sel;

  assign sel      = sel_e'(bus_addr);
  assign rd_end   = bus_rd & (sel == SEL_END);
  assign rd_start = bus_rd & (sel == SEL_START);
  assign clr_evt  = bus_wr & (sel == SEL_FLAG) & bus_wdata[0];

  pcc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .sig_in(sig_in), .edge_rise(edge_rise), .qual(qual)
  );

  pcc_shadow_regs #(.TB_W(TB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .qual(qual),
    .tbase(tbase), .rd_end(rd_end), .rd_start(rd_start),
    .a2(a2), .b1(b1), .first_edge(first_edge), .later_edge(later_edge)
  );

  pcc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .set_evt(later_edge), .clr_evt(clr_evt), .flag(flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_END:   bus_rdata = a2;
        SEL_START: bus_rdata = b1;
        SEL_FLAG:  bus_rdata[0] = flag;
        default:   bus_rdata = '0;
      endcase
    end
  end

  p_first_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (first_edge && mode_en && !flag) |=> !flag);
  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (a2 == '0 && b1 == '0));
  p_idle_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/tb_period_capture_chan.sv
module tb_period_capture_chan;
  localparam int TB_W = 24;

  logic clk = 0, rst_n = 0, sig_in = 0, edge_rise = 1, mode_en = 0;
  logic [TB_W-1:0] tbase = 24'h000100;
  logic [1:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [TB_W-1:0] bus_wdata = 0, bus_rdata;
  logic flag;
  int n_chk = 0, n_fail = 0;

  period_capture_chan #(.TB_W(TB_W)) dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) tbase <= tbase + 24'd3;

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic check(input string req, input logic [TB_W-1:0] act, input logic [TB_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // toggle input to make one edge; returns stamp captured at next posedge
  task automatic edge_to(input logic lvl, output logic [TB_W-1:0] stamp);
    sig_in = lvl; stamp = tbase; tick(); tick();
  endtask

  task automatic rd(input logic [1:0] a, output logic [TB_W-1:0] d);
    bus_addr = a; bus_rd = 1; #1 d = bus_rdata; tick(); bus_rd = 0; tick();
  endtask

  task automatic clr_flag();
    bus_addr = 2; bus_wr = 1; bus_wdata = 1; tick(); bus_wr = 0; bus_wdata = 0; tick();
  endtask

  task automatic restart(input logic rise);
    mode_en = 0; edge_rise = rise; sig_in = rise ? 1'b0 : 1'b1; tick(); tick();
    mode_en = 1; tick();
  endtask

  logic [TB_W-1:0] t1, t2, t3, t4, t5, d, tx;

  task automatic t_reset();
    logic [TB_W-1:0] r;
    rd(0, r); check("R10 reset A2", r, 0);
    rd(1, r); check("R10 reset B1", r, 0);
    check("R10 reset flag", flag, 0);
    bus_addr = 0; #1 check("R6 idle rdata", bus_rdata, 0); tick();
  endtask

  task automatic t_basic();
    restart(1);
    edge_to(1, t1);
    check("R4 no flag on first edge", flag, 0);
    rd(0, d); check("R2 A2 first stamp", d, t1);
    rd(1, d); check("R3 B1 after first edge (A1 still 0)", d, 0);
    edge_to(0, tx);              // falling: ignored
    rd(0, d); check("R1 falling ignored A2", d, t1);
    check("R1 falling no flag", flag, 0);
    edge_to(1, t2);
    check("R5 flag after second edge", flag, 1);
    rd(0, d); check("R2 A2 second stamp", d, t2);
    rd(1, d); check("R3 B1 start stamp", d, t1);
    check("R2 period", t2 - t1, d == t1 ? t2 - t1 : 0);
    rd(2, d); check("R6 flag readback", d, 1);
    sig_in = 0; tick(); tick();
    edge_to(1, t3);              // flag already set
    check("R9 flag sticky", flag, 1);
    clr_flag(); check("R9 W1C clears", flag, 0);
  endtask

  task automatic t_coherent();
    // state: A2=t3, B1=t2 (read B re-enabled), A1=t2, B2=t3
    rd(0, d); check("R7 port A end", d, t3);
    sig_in = 0; tick(); tick(); edge_to(1, t4);
    sig_in = 0; tick(); tick(); edge_to(1, t5);
    rd(1, d); check("R7 B1 frozen after port A read", d, t2);
    rd(0, d); check("R8 A2 newest", d, t5);
    rd(1, d); check("R8 B1 matched start", d, t4);
  endtask

  task automatic t_falling();
    restart(0);
    edge_to(0, t1);
    edge_to(1, tx);              // rising ignored
    check("R1 rising ignored no flag", flag, 0);
    edge_to(0, t2);
    rd(0, d); check("R1 falling A2", d, t2);
    rd(1, d); check("R1 falling B1", d, t1);
  endtask

  task automatic t_same_cycle();
    restart(1);
    edge_to(1, t1); sig_in = 0; tick(); tick();
    edge_to(1, t2); sig_in = 0; tick(); tick();
    // A2=t2 B2=t2 A1=t1 B1=t1; edge + read B in same clock
    sig_in = 1; t3 = tbase; bus_addr = 1; bus_rd = 1;
    #1 check("R11 read returns pre-edge B1", bus_rdata, t1);
    tick(); bus_rd = 0; tick();
    rd(1, d); check("R11 B1 = A1 after edge", d, t2);
    rd(0, d); check("R11 A2 captured", d, t3);
    // set beats clear in same cycle
    clr_flag(); sig_in = 0; tick(); tick();
    sig_in = 1; bus_addr = 2; bus_wr = 1; bus_wdata = 1; tick();
    bus_wr = 0; bus_wdata = 0; tick();
    check("R9 set wins over clear", flag, 1);
  endtask

  task automatic t_mode_off();
    mode_en = 0; tick(); tick();
    check("R10 mode off flag", flag, 0);
    rd(0, d); check("R10 mode off A2", d, 0);
    mode_en = 1; sig_in = 0; tick(); tick();
    edge_to(1, t1);
    check("R10 first edge again no flag", flag, 0);
    rd(1, d); check("R10 B1 cleared on re-entry", d, 0);
  endtask

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_basic();
    t_coherent();
    t_falling();
    t_same_cycle();
    t_mode_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule